// File: doc/BRIEF.md
# Paged Address Translator with Lookaside Cache

This block turns a 32-bit linear address into a physical address using fixed 4 KB pages. The upper 20 bits (the virtual page number) are looked up in a small fully associative lookaside cache of recent page-to-frame mappings. The lower 12 bits (the page offset) pass through unchanged. A hit answers in the cycle the request is raised. On a miss, a walker state machine reads one 32-bit table entry through a single-beat memory read port. The entry's address is the table-base register plus four times the page number. The walker then either fills the cache or reports a page fault.

A requester raises `req_valid` with `req_lin` and holds both until `req_ready` is high for one cycle. At that point `rsp_phys` carries the result, or `rsp_fault` flags a missing page. The faulting linear address is captured in `fault_addr`. The `pg_enable` input turns translation on. When it is low, the physical address equals the linear address and no table read is made. Writing a new table base empties the cache.

The walker has four states:
- `WS_IDLE`: serves hits and bypassed requests. It moves to `WS_ISSUE` on a translated miss.
- `WS_ISSUE`: pulses the memory read, then moves to `WS_WAIT`.
- `WS_WAIT`: waits for `mem_rd_valid`. It returns to `WS_IDLE` after a fill or a discarded walk, or moves to `WS_FAULT` when the present bit is clear.
- `WS_FAULT`: returns the fault response, then moves back to `WS_IDLE`.

Top module: `pgxlat_top`

## Requirements
- R1: For every non-fault response, `rsp_phys[11:0]` equals `req_lin[11:0]`.
- R2: With `pg_enable` low, a request gets `req_ready` in the same cycle it is raised, with `rsp_phys == req_lin` and no memory read.
- R3: With `pg_enable` high and the page present in the cache, `req_ready` rises in the same cycle with `rsp_phys = {cached frame, req_lin[11:0]}` and no memory read.
- R4: On a translated miss, exactly one single-cycle `mem_rd_req` is issued at address `base + {page number, 2'b00}`. A table entry uses bit 0 as the present bit and bits 31:12 as the frame number. If the entry is present, the cache is filled and `req_ready` is high in the cycle after `mem_rd_valid`, with `rsp_phys = {entry[31:12], req_lin[11:0]}`.
- R5: If the entry's bit 0 is 0, `req_ready` and `rsp_fault` are both high in the cycle after `mem_rd_valid`, and `fault_addr` already equals `req_lin` in that cycle. `fault_addr` changes at no other time. No cache fill takes place, so the same page walks again on its next request.
- R6: The cache holds 8 pages and is refilled in round-robin order. Once 8 pages are cached, a ninth miss displaces the oldest fill while the other seven still hit.
- R7: A `base_wr` pulse loads `base_wdata` into the table base and invalidates every cache entry. It also resets the round-robin position to the first entry.
- R8: A `base_wr` while a walk is in `WS_ISSUE` or `WS_WAIT` (including the cycle of `mem_rd_valid`) discards that walk's entry. The request then walks again using the new base.
- R9: While a walk is in progress `req_ready` stays low. `mem_rd_req` is never high in a cycle with `req_ready`.
- R10: After reset the cache is empty, the base is 0, `fault_addr` is 0 and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_enable | input | 1 | 1 = translate, 0 = physical equals linear |
| base_wr | input | 1 | Load table base and flush cache |
| base_wdata | input | 32 | New table base address |
| req_valid | input | 1 | Translation request, held until ready |
| req_lin | input | 32 | Linear address |
| req_ready | output | 1 | Response valid this cycle |
| rsp_phys | output | 32 | Physical address |
| rsp_fault | output | 1 | Page not present |
| fault_addr | output | 32 | Last faulting linear address |
| mem_rd_req | output | 1 | Single-cycle table read strobe |
| mem_rd_addr | output | 32 | Table entry byte address |
| mem_rd_valid | input | 1 | Table read data valid |
| mem_rd_data | input | 32 | Table entry |

## Verification
The bench goes after the eviction order by filling all eight entries and then missing once more. A design with a wrong replacement pointer would keep the oldest page, or drop a recent one, and a later request would show an unexpected table read. It writes the base while a walk is pending, including in the same cycle as the returned data. A design that let that stale entry into the cache would return a frame that belongs to the old table. It also drives non-present entries, where a faulty design would fill the cache or leave `fault_addr` stale. It drops `pg_enable` on requests whose pages are cached, where a faulty design would still translate. Random memory latency of one to four cycles checks that the response comes exactly one cycle after the data.

// File: rtl/pgxlat_pkg.sv
package pgxlat_pkg;
    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ISSUE = 2'd1,
        WS_WAIT  = 2'd2,
        WS_FAULT = 2'd3
    } walk_state_e;
endpackage

// File: rtl/pgxlat_tlb.sv
module pgxlat_tlb #(
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] match;
    logic [VPN_W-1:0] vpn_q [DEPTH];
    logic [PFN_W-1:0] pfn_q [DEPTH];
    logic [IDX_W-1:0] ptr_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (vpn_q[g] == look_vpn);
    end

    assign hit = |match;

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_pfn = hit_pfn | pfn_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (fill_en) begin
            vld_q[ptr_q] <= 1'b1;
            ptr_q        <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (fill_en && !flush && (ptr_q == IDX_W'(g))) begin
                vpn_q[g] <= fill_vpn;
                pfn_q[g] <= fill_pfn;
            end
        end
    end
endmodule

// File: rtl/pgxlat_regs.sv
module pgxlat_regs #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              fault_en,
    input  logic [ADDR_W-1:0] fault_lin,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] fault_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            fault_q <= '0;
        end else begin
            if (base_wr)  base_q  <= base_wdata;
            if (fault_en) fault_q <= fault_lin;
        end
    end
endmodule

// File: rtl/pgxlat_walker.sv
module pgxlat_walker
    import pgxlat_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pg_enable,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_lin,
    input  logic                        tlb_hit,
    input  logic [ADDR_W-PAGE_BITS-1:0] tlb_pfn,
    input  logic [ADDR_W-1:0]           base_q,
    input  logic                        base_wr,
    input  logic                        mem_rd_valid,
    input  logic                        pte_present,
    input  logic [ADDR_W-PAGE_BITS-1:0] pte_pfn,
    output logic                        req_ready,
    output logic [ADDR_W-1:0]           rsp_phys,
    output logic                        rsp_fault,
    output logic                        mem_rd_req,
    output logic [ADDR_W-1:0]           mem_rd_addr,
    output logic                        fill_en,
    output logic                        fault_en
);
    localparam int VPN_W   = ADDR_W - PAGE_BITS;
    localparam int PAD_W   = ADDR_W - VPN_W - 2;

    walk_state_e state_q, state_d;
    logic        cancel_q;
    logic        drop;
    logic [VPN_W-1:0] vpn;

    assign vpn  = req_lin[ADDR_W-1:PAGE_BITS];
    assign drop = cancel_q || base_wr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // walk cancellation on base rewrite
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == WS_IDLE)                       cancel_q <= 1'b0;
        else if (base_wr && (state_q inside {WS_ISSUE, WS_WAIT})) cancel_q <= 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (req_valid && pg_enable && !tlb_hit) state_d = WS_ISSUE;
            WS_ISSUE: state_d = WS_WAIT;
            WS_WAIT:  if (mem_rd_valid) begin
                          if (drop || pte_present) state_d = WS_IDLE;
                          else                     state_d = WS_FAULT;
                      end
            WS_FAULT: state_d = WS_IDLE;
            default:  state_d = WS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        rsp_fault   = 1'b0;
        rsp_phys    = '0;
        mem_rd_req  = 1'b0;
        fill_en     = 1'b0;
        fault_en    = 1'b0;
        mem_rd_addr = base_q + {{PAD_W{1'b0}}, vpn, 2'b00};
        unique case (state_q)
            WS_IDLE: begin
                if (!pg_enable) begin
                    req_ready = req_valid;
                    rsp_phys  = req_lin;
                end else begin
                    req_ready = req_valid && tlb_hit;
                    rsp_phys  = {tlb_pfn, req_lin[PAGE_BITS-1:0]};
                end
            end
            WS_ISSUE: mem_rd_req = 1'b1;
            WS_WAIT: begin
                fill_en  = mem_rd_valid && !drop && pte_present;
                fault_en = mem_rd_valid && !drop && !pte_present;
            end
            WS_FAULT: begin
                req_ready = 1'b1;
                rsp_fault = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pgxlat_top.sv
module pgxlat_top #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int TLB_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_enable,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_lin,
    output logic              req_ready,
    output logic [ADDR_W-1:0] rsp_phys,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [ADDR_W-1:0] mem_rd_data
);
    localparam int VPN_W = ADDR_W - PAGE_BITS;

    logic              tlb_hit;
    logic [VPN_W-1:0]  tlb_pfn;
    logic              fill_en;
    logic              fault_en;
    logic [ADDR_W-1:0] base_q;
    logic              unused_pte_bits;

    assign unused_pte_bits = ^mem_rd_data[PAGE_BITS-1:1];

    pgxlat_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .fault_en   (fault_en),
        .fault_lin  (req_lin),
        .base_q     (base_q),
        .fault_q    (fault_addr)
    );

    pgxlat_tlb #(.VPN_W(VPN_W), .PFN_W(VPN_W), .DEPTH(TLB_DEPTH)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (base_wr),
        .look_vpn (req_lin[ADDR_W-1:PAGE_BITS]),
        .hit      (tlb_hit),
        .hit_pfn  (tlb_pfn),
        .fill_en  (fill_en),
        .fill_vpn (req_lin[ADDR_W-1:PAGE_BITS]),
        .fill_pfn (mem_rd_data[ADDR_W-1:PAGE_BITS])
    );

    pgxlat_walker #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .pg_enable    (pg_enable),
        .req_valid    (req_valid),
        .req_lin      (req_lin),
        .tlb_hit      (tlb_hit),
        .tlb_pfn      (tlb_pfn),
        .base_q       (base_q),
        .base_wr      (base_wr),
        .mem_rd_valid (mem_rd_valid),
        .pte_present  (mem_rd_data[0]),
        .pte_pfn      (mem_rd_data[ADDR_W-1:PAGE_BITS]),
        .req_ready    (req_ready),
        .rsp_phys     (rsp_phys),
        .rsp_fault    (rsp_fault),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .fill_en      (fill_en),
        .fault_en     (fault_en)
    );
endmodule

// File: rtl/pgxlat_chk.sv
module pgxlat_chk #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pg_enable,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_lin,
    input logic [ADDR_W-1:0] rsp_phys,
    input logic              rsp_fault,
    input logic [ADDR_W-1:0] fault_addr,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr
);
    p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !rsp_fault) |-> rsp_phys[PAGE_BITS-1:0] == req_lin[PAGE_BITS-1:0]);

    p_bypass_ident_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !rsp_fault && !pg_enable) |-> rsp_phys == req_lin);

    p_read_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    p_read_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> mem_rd_addr[1:0] == 2'b00);

    p_fault_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && rsp_fault) |-> fault_addr == req_lin);

    p_fault_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr) |-> (req_ready && rsp_fault));

    p_no_ready_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);
endmodule

bind pgxlat_top pgxlat_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (.*);

// File: tb/pgxlat_top_test.sv
`timescale 1ns/1ps
module pgxlat_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_enable = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_ready;
    logic [31:0] rsp_phys;
    logic        rsp_fault;
    logic [31:0] fault_addr;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int nchk = 0, nfail = 0;
    int cyc = 0;
    int rd_count = 0;
    int data_cyc = -10;
    logic [31:0] last_rd_addr = '0;

    // reference model
    logic [31:0] m_base = '0;
    logic [19:0] m_vpn [8];
    bit          m_vld [8];
    int          m_ptr = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pgxlat_top uut (.*);

    function automatic logic [31:0] pte_for(input logic [31:0] a);
        logic [31:0] h;
        h = a * 32'h9E3779B1 + 32'h01234567;
        h = h ^ (h >> 15);
        return {h[31:12], 11'h0, (h[7:4] != 4'h0)};
    endfunction

    function automatic logic [31:0] pte_addr(input logic [31:0] b, input logic [19:0] v);
        return b + {10'h0, v, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic m_flush(input logic [31:0] nb);
        for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
        m_ptr  = 0;
        m_base = nb;
    endtask

    task automatic write_base(input logic [31:0] nb);
        @(negedge clk);
        base_wr = 1'b1; base_wdata = nb;
        @(negedge clk);
        base_wr = 1'b0;
        m_flush(nb);
    endtask

    // memory model: random latency 1..4 cycles
    initial begin
        int cnt = 0;
        logic [31:0] pend = '0;
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = pte_for(pend);
                    data_cyc     = cyc;
                end
            end
            if (mem_rd_req) begin
                rd_count++;
                last_rd_addr = mem_rd_addr;
                pend = mem_rd_addr;
                cnt  = 1 + int'($urandom % 4);
            end
        end
    end

    // one request; wr_at >= 0 injects a base write on that cycle of the walk
    task automatic do_req(input logic [31:0] lin, input bit en, input int wr_at,
                          input logic [31:0] nb, input string tag);
        int          c;
        int          rd0;
        bit          hit, walk, exp_fault;
        int          exp_reads;
        logic [31:0] exp_phys, pte, pa;
        logic [19:0] vpn;
        vpn = lin[31:12];
        rd0 = rd_count;
        @(negedge clk);
        pg_enable = en; req_lin = lin; req_valid = 1'b1;
        hit = 1'b0;
        for (int i = 0; i < 8; i++) if (m_vld[i] && m_vpn[i] == vpn) hit = 1'b1;
        if (wr_at >= 0 && en && !hit) m_flush(nb);
        walk = en && !hit;
        exp_fault = 1'b0; exp_phys = lin; exp_reads = 0; pa = '0;
        if (en && hit) begin
            for (int i = 0; i < 8; i++)
                if (m_vld[i] && m_vpn[i] == vpn) exp_phys = {pte_for(pte_addr(m_base, m_vpn[i]))[31:12], lin[11:0]};
        end else if (walk) begin
            pa  = pte_addr(m_base, vpn);
            pte = pte_for(pa);
            exp_reads = (wr_at >= 0) ? 2 : 1;
            if (pte[0]) begin
                exp_phys = {pte[31:12], lin[11:0]};
                m_vpn[m_ptr] = vpn; m_vld[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 8;
            end else begin
                exp_fault = 1'b1;
            end
        end
        c = 0;
        #1;
        while (!req_ready && c < 100) begin
            @(negedge clk);
            c++;
            base_wr = (c == wr_at); base_wdata = nb;
            #1;
        end
        base_wr = 1'b0;
        chk(req_ready, {tag, " ready seen"}, 32'(req_ready), 32'd1);
        chk(rsp_fault == exp_fault, {tag, " fault flag"}, 32'(rsp_fault), 32'(exp_fault));
        if (!exp_fault) chk(rsp_phys == exp_phys, {tag, " phys"}, rsp_phys, exp_phys);
        else            chk(fault_addr == lin, {tag, " R5 fault_addr"}, fault_addr, lin);
        chk(rd_count - rd0 == exp_reads, {tag, " read count"}, 32'(rd_count - rd0), 32'(exp_reads));
        if (!walk) chk(c == 0, {tag, " same-cycle ready"}, 32'(c), 32'd0);
        else begin
            chk(cyc == data_cyc + 1, {tag, " ready after data"}, 32'(cyc), 32'(data_cyc + 1));
            chk(last_rd_addr == pa, {tag, " R4 table address"}, last_rd_addr, pa);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [19:0] find_vpn(input logic [31:0] b, input logic [19:0] start, input bit want);
        for (int v = 0; v < 4096; v++) begin
            logic [19:0] cand;
            cand = start + 20'(v);
            if (pte_for(pte_addr(b, cand))[0] == want) return cand;
        end
        return start;
    endfunction

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog expired act=%0d exp=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [19:0] pv [9];
        logic [19:0] nv;
        void'($urandom(32'd20240611));
        m_flush('0);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(req_ready == 1'b0, "R10 ready low", 32'(req_ready), 0);
        chk(fault_addr == 0, "R10 fault_addr", fault_addr, 0);
        chk(mem_rd_req == 1'b0, "R10 no read", 32'(mem_rd_req), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R10 ready after reset", 32'(req_ready), 0);
        // R4/R10: first miss reads from base 0
        nv = find_vpn('0, 20'h00040, 1'b1);
        do_req({nv, 12'h5A4}, 1'b1, -1, '0, "R4 R10 first miss");
        // R3 hit
        do_req({nv, 12'h013}, 1'b1, -1, '0, "R3 hit");
        // R2 bypass on a cached page and elsewhere
        do_req({nv, 12'hFFF}, 1'b0, -1, '0, "R2 bypass cached");
        do_req(32'hDEAD_BEEF, 1'b0, -1, '0, "R2 bypass");
        // R5 fault and no fill
        nv = find_vpn('0, 20'h00300, 1'b0);
        do_req({nv, 12'h777}, 1'b1, -1, '0, "R5 fault");
        do_req({nv, 12'h778}, 1'b1, -1, '0, "R5 refault rewalk");
        // R6 round robin eviction
        write_base(32'h0010_0000);
        pv[0] = find_vpn(m_base, 20'h01000, 1'b1);
        for (int i = 1; i < 9; i++) pv[i] = find_vpn(m_base, pv[i-1] + 20'd1, 1'b1);
        for (int i = 0; i < 8; i++) do_req({pv[i], 12'h100}, 1'b1, -1, '0, "R6 fill");
        for (int i = 0; i < 8; i++) do_req({pv[i], 12'h204}, 1'b1, -1, '0, "R6 all hit");
        do_req({pv[8], 12'h0}, 1'b1, -1, '0, "R6 ninth miss");
        do_req({pv[0], 12'h0}, 1'b1, -1, '0, "R6 oldest evicted");
        for (int i = 2; i < 9; i++) do_req({pv[i], 12'hABC}, 1'b1, -1, '0, "R6 others hit");
        // R7 base write flush
        write_base(32'h0020_0000);
        do_req({pv[3], 12'h321}, 1'b1, -1, '0, "R7 flushed rewalk");
        // R8 base write during walk
        do_req({pv[5], 12'h444}, 1'b1, 1, 32'h0030_0000, "R8 cancel issue");
        do_req({pv[6], 12'h445}, 1'b1, 2, 32'h0040_0000, "R8 cancel wait");
        do_req({pv[6], 12'h446}, 1'b1, -1, '0, "R8 R3 hit after rewalk");
        // random mix, R1 R3 R4 R5 R6 R9
        for (int n = 0; n < 400; n++) begin
            logic [31:0] lin;
            int r;
            r = int'($urandom % 100);
            lin = {20'h07000 + 20'(($urandom % 12) * 3), 12'($urandom)};
            if (r < 4) write_base((($urandom % 2) == 0) ? 32'h0050_0000 : 32'h0060_0000);
            else if (r < 8) do_req(lin, 1'b1, 1 + int'($urandom % 2), 32'h0070_0000, "R8 random cancel");
            else do_req(lin, (r >= 14), -1, '0, "R1 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule